// File: doc/BRIEF.md
# Instruction Cache Tag Lookup and Check

This block is the tag side of an instruction cache with a configurable number of ways (eight by default). It holds the tag array. Each entry stores a tag, an even-parity bit over that tag, and two copies of the line-valid bit. A fetch lookup names a set and a tag. The block reads every way of that set and returns exactly one of three results: a hit on one way, a miss, or a typed error. Each error class is checked only when its enable bit is set.

The block also repairs and fills the array on its own. After any reported error it wipes every way of the looked-up set. After a clean miss it allocates a victim way, chosen by a round-robin counter, and writes a fresh entry. Two side paths leave the response port silent. A flush removes matching lines from a set. A diagnostic port writes a single entry, with optional deliberate parity or valid-copy corruption, and reads any entry back. The data array and line fills from memory belong to the surrounding cache.

Top module: `itag_lookup`

## Requirements
- R1: A lookup request sampled at a clock edge produces a response at the second edge after it. `rsp_vld` is high for exactly one cycle. Outside that cycle `rsp_hit`, `rsp_err` and `rsp_type` are all zero.
- R2: Entry fields are tag, parity, valid copy 1 and valid copy 0. A way counts as valid when either valid copy is 1. A way matches when it is valid and its tag equals the lookup tag. If no error is reported and a way matches, the response gives `rsp_hit`=1, `rsp_err`=0, `rsp_type`=0, and `rsp_way` set to the highest-numbered matching way.
- R3: When `chk_en[0]` is 1 and any way of the set has its two valid copies unequal, the response reports error type 1 with `rsp_way` set to the lowest such way. This check outranks every other check. When `chk_en[0]` is 0, such a way is treated as valid.
- R4: When `chk_en[1]` is 1 and no type-1 error is reported, a valid way whose stored parity differs from the XOR of its tag bits gives error type 2, with `rsp_way` set to the lowest such way. Invalid ways are never parity-checked.
- R5: When `chk_en[2]` is 1, no higher-priority error is reported, and two or more ways match, the response reports error type 3 with `rsp_way` set to the second-lowest matching way. When `chk_en[2]` is 0, the lookup is a hit under R2.
- R6: When a lookup would otherwise hit, `chk_en[3]` is 1 and bit [hit way] of the `lk_ipar_bad` vector captured with the request is 1, the response reports error type 4 with `rsp_way` set to the hit way.
- R7: After an error response, every way of the looked-up set reads back with both valid copies 0. Other sets are untouched.
- R8: A clean miss reports `rsp_hit`=0, `rsp_err`=0, `rsp_type`=0 and `rsp_way` set to the victim way. The victim way comes from a counter that is 0 after reset and advances by one, modulo the number of ways, on each miss allocation. The victim entry is written with the lookup tag, parity equal to the XOR of the tag bits, and both valid copies set to 1.
- R9: A diagnostic write stores `dg_tag`. Its parity is the XOR of the `dg_tag` bits XORed with `dg_par_inj`. Valid copy 1 is `dg_v1`, and valid copy 0 is `dg_v1` XOR `dg_vld_inj`. The diagnostic read port returns the stored fields of the addressed entry.
- R10: A flush clears the whole entry of every valid way in `fl_set` whose tag equals `fl_tag`. It runs no error checks and produces no response. Other ways are unchanged.
- R11: After reset every entry reads as zero, all response outputs are low, and the first miss allocates way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_set | input | IDX_W | Set index of the lookup |
| lk_tag | input | TAG_W | Tag of the lookup |
| lk_ipar_bad | input | WAYS | Per-way instruction parity mismatch flags from the data array |
| chk_en | input | 4 | Check enables: [0] valid pair, [1] tag parity, [2] multi-hit, [3] instruction parity |
| fl_req | input | 1 | Flush request |
| fl_set | input | IDX_W | Set index of the flush |
| fl_tag | input | TAG_W | Tag to flush |
| dg_wr | input | 1 | Diagnostic write strobe |
| dg_set | input | IDX_W | Set of the diagnostic write |
| dg_way | input | WAY_W | Way of the diagnostic write |
| dg_tag | input | TAG_W | Tag to write |
| dg_v1 | input | 1 | Valid copy 1 to write |
| dg_par_inj | input | 1 | Inverts the computed parity |
| dg_vld_inj | input | 1 | Makes valid copy 0 differ from copy 1 |
| dg_rd_set | input | IDX_W | Set of the diagnostic read |
| dg_rd_way | input | WAY_W | Way of the diagnostic read |
| dg_rd_tag | output | TAG_W | Stored tag |
| dg_rd_par | output | 1 | Stored parity bit |
| dg_rd_v1 | output | 1 | Stored valid copy 1 |
| dg_rd_v0 | output | 1 | Stored valid copy 0 |
| rsp_vld | output | 1 | Lookup response strobe |
| rsp_hit | output | 1 | Clean hit |
| rsp_way | output | WAY_W | Hit way, victim way, or offending way |
| rsp_err | output | 1 | Error reported |
| rsp_type | output | 3 | Error type 0 to 4 |

## Verification
The assertions assume one operation at a time. A flush or diagnostic write never arrives in the same cycle as a lookup request, nor in the cycle after one while that lookup is being resolved, because both the flush and the diagnostic write share the array's single write port with the lookup result. The bench keeps within this by running every operation in its own task. Each task finishes the operation and returns the inputs to idle before the next one starts. Diagnostic reads are purely combinational and may happen at any time.

// File: rtl/itag_pkg.sv
package itag_pkg;

   // error classes, ordered by reporting priority
   typedef enum logic [2:0] {
      ET_NONE  = 3'd0,
      ET_VPAIR = 3'd1,
      ET_TPAR  = 3'd2,
      ET_MULTI = 3'd3,
      ET_IPAR  = 3'd4
   } etype_e;

   // bit positions inside the check-enable vector
   localparam int EN_VPAIR = 0;
   localparam int EN_TPAR  = 1;
   localparam int EN_MULTI = 2;
   localparam int EN_IPAR  = 3;
   localparam int EN_W     = 4;

   // entry layout: {tag, parity, valid1, valid0}
   localparam int F_V0  = 0;
   localparam int F_V1  = 1;
   localparam int F_PAR = 2;
   localparam int F_TAG = 3;

endpackage

// File: rtl/itag_array.sv
module itag_array #(
   parameter  int SETS  = 16,
   parameter  int WAYS  = 8,
   parameter  int ENT_W = 15,
   parameter  int NRD   = 4,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [WAYS-1:0]                     wr_mask,
   input  logic [IDX_W-1:0]                    wr_set,
   input  logic [ENT_W-1:0]                    wr_data,
   input  logic [NRD-1:0][IDX_W-1:0]           rd_set,
   output logic [NRD-1:0][WAYS-1:0][ENT_W-1:0] rd_data
);

   if (SETS < 2 || (1 << IDX_W) != SETS) begin : g_bad_sets
      $error("itag_array: SETS must be a power of two, at least 2");
   end
   if (NRD < 1) begin : g_bad_nrd
      $error("itag_array: need at least one read port");
   end

   logic [WAYS-1:0][ENT_W-1:0] mem [SETS];

   // one masked write port: any subset of the ways of one set per cycle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) mem[s] <= '0;
      end else begin
         for (int w = 0; w < WAYS; w++) begin
            if (wr_mask[w]) mem[wr_set][w] <= wr_data;
         end
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rd_data[p] = mem[rd_set[p]];
   end

endmodule

// File: rtl/itag_way_check.sv
module itag_way_check
   import itag_pkg::*;
#(
   parameter  int TAG_W = 12,
   localparam int ENT_W = TAG_W + 3
) (
   input  logic [ENT_W-1:0] ent,
   input  logic [TAG_W-1:0] tag,
   output logic             pair_bad,
   output logic             par_bad,
   output logic             tag_hit
);

   logic             v0, v1, par, vld;
   logic [TAG_W-1:0] etag;

   assign v0   = ent[F_V0];
   assign v1   = ent[F_V1];
   assign par  = ent[F_PAR];
   assign etag = ent[F_TAG +: TAG_W];
   assign vld  = v0 | v1;

   assign pair_bad = v0 ^ v1;
   assign par_bad  = vld & ((^etag) != par);
   assign tag_hit  = vld & (etag == tag);

endmodule

// File: rtl/itag_resolve.sv
module itag_resolve
   import itag_pkg::*;
#(
   parameter  int WAYS  = 8,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0] pair_bad,
   input  logic [WAYS-1:0] par_bad,
   input  logic [WAYS-1:0] tag_hit,
   input  logic [WAYS-1:0] ipar_bad,
   input  logic [EN_W-1:0] en,
   output logic            hit,
   output logic            err,
   output etype_e          etype,
   output logic [WAY_W-1:0] way
);

   logic [WAY_W-1:0] lo_pair, lo_par, hi_hit, second_hit;
   logic             seen_hit, two_hits;

   // lowest offending ways
   always_comb begin
      lo_pair = '0;
      lo_par  = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (pair_bad[w]) lo_pair = WAY_W'(w);
         if (par_bad[w])  lo_par  = WAY_W'(w);
      end
   end

   // highest matching way and second-lowest matching way
   always_comb begin
      hi_hit     = '0;
      second_hit = '0;
      seen_hit   = 1'b0;
      two_hits   = 1'b0;
      for (int w = 0; w < WAYS; w++) begin
         if (tag_hit[w]) begin
            if (seen_hit && !two_hits) begin
               second_hit = WAY_W'(w);
               two_hits   = 1'b1;
            end
            seen_hit = 1'b1;
            hi_hit   = WAY_W'(w);
         end
      end
   end

   // fixed priority: valid pair, tag parity, multi-hit, instruction parity
   always_comb begin
      hit   = 1'b0;
      err   = 1'b0;
      etype = ET_NONE;
      way   = '0;
      if (en[EN_VPAIR] && |pair_bad) begin
         err = 1'b1; etype = ET_VPAIR; way = lo_pair;
      end else if (en[EN_TPAR] && |par_bad) begin
         err = 1'b1; etype = ET_TPAR; way = lo_par;
      end else if (en[EN_MULTI] && two_hits) begin
         err = 1'b1; etype = ET_MULTI; way = second_hit;
      end else if (seen_hit && en[EN_IPAR] && ipar_bad[hi_hit]) begin
         err = 1'b1; etype = ET_IPAR; way = hi_hit;
      end else if (seen_hit) begin
         hit = 1'b1; way = hi_hit;
      end
   end

endmodule

// File: rtl/itag_victim.sv
module itag_victim #(
   parameter  int WAYS  = 8,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [WAY_W-1:0] way
);

   if (WAYS < 2) begin : g_bad_ways
      $error("itag_victim: WAYS must be at least 2");
   end

   if ((1 << WAY_W) == WAYS) begin : g_pow2
      // natural wrap of the counter
      always_ff @(posedge clk) begin
         if (!rst_n)   way <= '0;
         else if (adv) way <= way + 1'b1;
      end
   end else begin : g_mod
      always_ff @(posedge clk) begin
         if (!rst_n)   way <= '0;
         else if (adv) way <= (way == WAY_W'(WAYS - 1)) ? '0 : way + 1'b1;
      end
   end

   p_victim_range_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      32'(way) < WAYS);

endmodule

// File: rtl/itag_lookup.sv
module itag_lookup
   import itag_pkg::*;
#(
   parameter  int WAYS  = 8,
   parameter  int SETS  = 16,
   parameter  int TAG_W = 12,
   localparam int WAY_W = $clog2(WAYS),
   localparam int IDX_W = $clog2(SETS),
   localparam int ENT_W = TAG_W + 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_req,
   input  logic [IDX_W-1:0] lk_set,
   input  logic [TAG_W-1:0] lk_tag,
   input  logic [WAYS-1:0]  lk_ipar_bad,
   input  logic [3:0]       chk_en,
   input  logic             fl_req,
   input  logic [IDX_W-1:0] fl_set,
   input  logic [TAG_W-1:0] fl_tag,
   input  logic             dg_wr,
   input  logic [IDX_W-1:0] dg_set,
   input  logic [WAY_W-1:0] dg_way,
   input  logic [TAG_W-1:0] dg_tag,
   input  logic             dg_v1,
   input  logic             dg_par_inj,
   input  logic             dg_vld_inj,
   input  logic [IDX_W-1:0] dg_rd_set,
   input  logic [WAY_W-1:0] dg_rd_way,
   output logic [TAG_W-1:0] dg_rd_tag,
   output logic             dg_rd_par,
   output logic             dg_rd_v1,
   output logic             dg_rd_v0,
   output logic             rsp_vld,
   output logic             rsp_hit,
   output logic [WAY_W-1:0] rsp_way,
   output logic             rsp_err,
   output logic [2:0]       rsp_type
);

   if (TAG_W < 1) begin : g_bad_tag
      $error("itag_lookup: TAG_W must be positive");
   end

   localparam int NRD   = 4;
   localparam int RP_LK = 0;
   localparam int RP_FL = 1;
   localparam int RP_DG = 2;
   localparam int RP_CK = 3;

   // ---------------- request stage ----------------
   logic             req_q;
   logic [IDX_W-1:0] req_set_q;
   logic [TAG_W-1:0] req_tag_q;
   logic [WAYS-1:0]  req_ipar_q;
   logic [EN_W-1:0]  req_en_q;
   logic [IDX_W-1:0] rsp_set_q;
   logic [TAG_W-1:0] rsp_tag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q      <= 1'b0;
         req_set_q  <= '0;
         req_tag_q  <= '0;
         req_ipar_q <= '0;
         req_en_q   <= '0;
      end else begin
         req_q <= lk_req;
         if (lk_req) begin
            req_set_q  <= lk_set;
            req_tag_q  <= lk_tag;
            req_ipar_q <= lk_ipar_bad;
            req_en_q   <= chk_en;
         end
      end
   end

   // ---------------- tag array ----------------
   logic [WAYS-1:0]                     wr_mask;
   logic [IDX_W-1:0]                    wr_set;
   logic [ENT_W-1:0]                    wr_data;
   logic [NRD-1:0][IDX_W-1:0]           rd_set;
   logic [NRD-1:0][WAYS-1:0][ENT_W-1:0] rd_data;

   assign rd_set[RP_LK] = req_set_q;
   assign rd_set[RP_FL] = fl_set;
   assign rd_set[RP_DG] = dg_rd_set;
   assign rd_set[RP_CK] = rsp_set_q;

   itag_array #(.SETS(SETS), .WAYS(WAYS), .ENT_W(ENT_W), .NRD(NRD)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_mask (wr_mask),
      .wr_set  (wr_set),
      .wr_data (wr_data),
      .rd_set  (rd_set),
      .rd_data (rd_data)
   );

   // ---------------- per-way checks ----------------
   logic [WAYS-1:0] lk_pair, lk_par, lk_hit, fl_hit;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      itag_way_check #(.TAG_W(TAG_W)) u_chk (
         .ent      (rd_data[RP_LK][w]),
         .tag      (req_tag_q),
         .pair_bad (lk_pair[w]),
         .par_bad  (lk_par[w]),
         .tag_hit  (lk_hit[w])
      );
      // flush compares tags only, no checking
      assign fl_hit[w] = (rd_data[RP_FL][w][F_V0] | rd_data[RP_FL][w][F_V1]) &&
                         (rd_data[RP_FL][w][F_TAG +: TAG_W] == fl_tag);
   end

   // ---------------- resolution ----------------
   logic             res_hit, res_err;
   etype_e           res_type;
   logic [WAY_W-1:0] res_way, vict_way;
   logic             alloc;

   itag_resolve #(.WAYS(WAYS)) u_resolve (
      .pair_bad (lk_pair),
      .par_bad  (lk_par),
      .tag_hit  (lk_hit),
      .ipar_bad (req_ipar_q),
      .en       (req_en_q),
      .hit      (res_hit),
      .err      (res_err),
      .etype    (res_type),
      .way      (res_way)
   );

   assign alloc = req_q & ~res_err & ~res_hit;

   itag_victim #(.WAYS(WAYS)) u_victim (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (alloc),
      .way   (vict_way)
   );

   // ---------------- write arbitration ----------------
   always_comb begin
      wr_mask = '0;
      wr_set  = req_set_q;
      wr_data = '0;
      if (req_q) begin
         if (res_err) begin
            wr_mask = '1;
         end else if (!res_hit) begin
            wr_mask = WAYS'(1) << vict_way;
            wr_data = {req_tag_q, ^req_tag_q, 1'b1, 1'b1};
         end
      end else if (fl_req) begin
         wr_mask = fl_hit;
         wr_set  = fl_set;
      end else if (dg_wr) begin
         wr_mask = WAYS'(1) << dg_way;
         wr_set  = dg_set;
         wr_data = {dg_tag, (^dg_tag) ^ dg_par_inj, dg_v1, dg_v1 ^ dg_vld_inj};
      end
   end

   // ---------------- response stage ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_vld   <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_type  <= '0;
         rsp_way   <= '0;
         rsp_set_q <= '0;
         rsp_tag_q <= '0;
      end else begin
         rsp_vld   <= req_q;
         rsp_hit   <= req_q & res_hit;
         rsp_err   <= req_q & res_err;
         rsp_type  <= req_q ? 3'(res_type) : 3'd0;
         rsp_way   <= !req_q ? '0 : ((res_hit || res_err) ? res_way : vict_way);
         rsp_set_q <= req_set_q;
         rsp_tag_q <= req_tag_q;
      end
   end

   // ---------------- diagnostic read ----------------
   logic [ENT_W-1:0] dg_ent;
   assign dg_ent    = rd_data[RP_DG][dg_rd_way];
   assign dg_rd_tag = dg_ent[F_TAG +: TAG_W];
   assign dg_rd_par = dg_ent[F_PAR];
   assign dg_rd_v1  = dg_ent[F_V1];
   assign dg_rd_v0  = dg_ent[F_V0];

   // ---------------- assertions ----------------
   logic [WAYS-1:0]  ck_vmask;
   logic [ENT_W-1:0] ck_ent;

   always_comb begin
      for (int w = 0; w < WAYS; w++) begin
         ck_vmask[w] = rd_data[RP_CK][w][F_V0] | rd_data[RP_CK][w][F_V1];
      end
   end
   assign ck_ent = rd_data[RP_CK][rsp_way];

   p_op_excl_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      (fl_req || dg_wr) |-> !(lk_req || req_q));

   p_rsp_latency_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |-> ##2 rsp_vld);

   p_rsp_quiet_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_vld |-> (!rsp_hit && !rsp_err && rsp_type == 3'd0));

   p_hit_err_excl_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_hit && rsp_err));

   p_err_type_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_type inside {3'd1, 3'd2, 3'd3, 3'd4}));

   p_set_wiped_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (ck_vmask == '0));

   p_alloc_clean_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && !rsp_hit && !rsp_err) |->
         (ck_ent[F_TAG +: TAG_W] == rsp_tag_q && ck_ent[F_V0] && ck_ent[F_V1] &&
          ck_ent[F_PAR] == ^rsp_tag_q));

endmodule

// File: tb/tb_itag_lookup.sv
module tb_itag_lookup;

   localparam int CLK_P = 10;
   localparam int WAYS  = 8;
   localparam int SETS  = 16;
   localparam int TAG_W = 12;
   localparam int WAY_W = 3;
   localparam int IDX_W = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             lk_req = 1'b0;
   logic [IDX_W-1:0] lk_set = '0;
   logic [TAG_W-1:0] lk_tag = '0;
   logic [WAYS-1:0]  lk_ipar_bad = '0;
   logic [3:0]       chk_en = '0;
   logic             fl_req = 1'b0;
   logic [IDX_W-1:0] fl_set = '0;
   logic [TAG_W-1:0] fl_tag = '0;
   logic             dg_wr = 1'b0;
   logic [IDX_W-1:0] dg_set = '0;
   logic [WAY_W-1:0] dg_way = '0;
   logic [TAG_W-1:0] dg_tag = '0;
   logic             dg_v1 = 1'b0;
   logic             dg_par_inj = 1'b0;
   logic             dg_vld_inj = 1'b0;
   logic [IDX_W-1:0] dg_rd_set = '0;
   logic [WAY_W-1:0] dg_rd_way = '0;
   logic [TAG_W-1:0] dg_rd_tag;
   logic             dg_rd_par, dg_rd_v1, dg_rd_v0;
   logic             rsp_vld, rsp_hit, rsp_err;
   logic [WAY_W-1:0] rsp_way;
   logic [2:0]       rsp_type;

   int n_chk = 0;
   int n_err = 0;
   int exp_vict = 0;

   // captured response
   logic             c_vld, c_hit, c_err;
   logic [WAY_W-1:0] c_way;
   logic [2:0]       c_type;

   always #(CLK_P / 2) clk = ~clk;

   itag_lookup #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) dut (.*);

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic lookup(input int set, input int tag, input logic [7:0] ipar, input logic [3:0] en);
      @(negedge clk);
      lk_req = 1'b1; lk_set = IDX_W'(set); lk_tag = TAG_W'(tag);
      lk_ipar_bad = ipar; chk_en = en;
      @(negedge clk);
      lk_req = 1'b0; lk_ipar_bad = '0;
      @(negedge clk);
      c_vld = rsp_vld; c_hit = rsp_hit; c_err = rsp_err; c_way = rsp_way; c_type = rsp_type;
   endtask

   task automatic dwrite(input int set, input int way, input int tag,
                         input logic v1, input logic pinj, input logic vinj);
      @(negedge clk);
      dg_wr = 1'b1; dg_set = IDX_W'(set); dg_way = WAY_W'(way); dg_tag = TAG_W'(tag);
      dg_v1 = v1; dg_par_inj = pinj; dg_vld_inj = vinj;
      @(negedge clk);
      dg_wr = 1'b0;
   endtask

   task automatic dread(input int set, input int way);
      dg_rd_set = IDX_W'(set); dg_rd_way = WAY_W'(way);
      #1;
   endtask

   task automatic flush(input int set, input int tag);
      @(negedge clk);
      fl_req = 1'b1; fl_set = IDX_W'(set); fl_tag = TAG_W'(tag);
      @(negedge clk);
      fl_req = 1'b0;
   endtask

   task automatic expect_rsp(input string rq, input logic hit, input logic err,
                             input int typ, input int way);
      chk({rq, " rsp_vld"}, 32'(c_vld), 32'd1);
      chk({rq, " rsp_hit"}, 32'(c_hit), 32'(hit));
      chk({rq, " rsp_err"}, 32'(c_err), 32'(err));
      chk({rq, " rsp_type"}, 32'(c_type), 32'(typ));
      chk({rq, " rsp_way"}, 32'(c_way), 32'(way));
   endtask

   task automatic expect_miss(input string rq);
      expect_rsp(rq, 1'b0, 1'b0, 0, exp_vict);
      exp_vict = (exp_vict + 1) % WAYS;
   endtask

   task automatic expect_set_empty(input string rq, input int set);
      for (int w = 0; w < WAYS; w++) begin
         dread(set, w);
         chk(rq, {30'd0, dg_rd_v1, dg_rd_v0}, 32'd0);
      end
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset;
      chk("R11 rsp_vld after reset", 32'(rsp_vld), 0);
      chk("R11 rsp_hit after reset", 32'(rsp_hit), 0);
      chk("R11 rsp_err after reset", 32'(rsp_err), 0);
      dread(3, 5);
      chk("R11 entry zero after reset", {dg_rd_tag, dg_rd_par, dg_rd_v1, dg_rd_v0}, 0);
      expect_set_empty("R11 set 12 empty", 12);
   endtask

   task automatic t_diag;
      dwrite(1, 2, 'hA5C, 1'b1, 1'b0, 1'b0);
      dread(1, 2);
      chk("R9 tag", 32'(dg_rd_tag), 32'hA5C);
      chk("R9 parity", 32'(dg_rd_par), 32'(^12'hA5C));
      chk("R9 valid copies", {dg_rd_v1, dg_rd_v0}, 32'd3);
      dwrite(1, 3, 'h001, 1'b1, 1'b1, 1'b1);
      dread(1, 3);
      chk("R9 injected parity", 32'(dg_rd_par), 32'(1'b1 ^ 1'b1));
      chk("R9 injected valid", {dg_rd_v1, dg_rd_v0}, 32'd2);
   endtask

   task automatic t_miss_hit;
      lookup(4, 'h100, 8'h00, 4'hF);
      expect_miss("R11 first miss way 0 / R8");
      lookup(4, 'h200, 8'h00, 4'hF);
      expect_miss("R8 second miss");
      dread(4, 0);
      chk("R8 alloc tag", 32'(dg_rd_tag), 32'h100);
      chk("R8 alloc parity", 32'(dg_rd_par), 32'(^12'h100));
      chk("R8 alloc valids", {dg_rd_v1, dg_rd_v0}, 32'd3);
      lookup(4, 'h100, 8'hFE, 4'hF);
      expect_rsp("R2 hit way 0", 1'b1, 1'b0, 0, 0);
      lookup(4, 'h200, 8'hFD, 4'hF);
      expect_rsp("R2 hit way 1", 1'b1, 1'b0, 0, 1);
   endtask

   task automatic t_ipar;
      lookup(4, 'h200, 8'h02, 4'h7);
      expect_rsp("R6 disabled gives hit", 1'b1, 1'b0, 0, 1);
      lookup(4, 'h200, 8'h02, 4'hF);
      expect_rsp("R6 instruction parity", 1'b0, 1'b1, 4, 1);
      expect_set_empty("R7 set 4 wiped", 4);
      dread(1, 2);
      chk("R7 other set untouched", {dg_rd_v1, dg_rd_v0}, 32'd3);
   endtask

   task automatic t_vpair;
      dwrite(5, 6, 'h333, 1'b0, 1'b0, 1'b1);
      dwrite(5, 2, 'h044, 1'b1, 1'b0, 1'b1);
      lookup(5, 'h777, 8'h00, 4'hF);
      expect_rsp("R3 valid pair lowest way", 1'b0, 1'b1, 1, 2);
      expect_set_empty("R7 set 5 wiped", 5);
      dwrite(5, 6, 'h333, 1'b0, 1'b0, 1'b1);
      lookup(5, 'h333, 8'h00, 4'hE);
      expect_rsp("R3 disabled pair counts valid", 1'b1, 1'b0, 0, 6);
   endtask

   task automatic t_tpar;
      dwrite(6, 3, 'h050, 1'b1, 1'b1, 1'b0);
      dwrite(6, 5, 'h066, 1'b1, 1'b0, 1'b1);
      lookup(6, 'h050, 8'h00, 4'hF);
      expect_rsp("R3 pair outranks parity", 1'b0, 1'b1, 1, 5);
      dwrite(6, 3, 'h050, 1'b1, 1'b1, 1'b0);
      dwrite(6, 5, 'h066, 1'b1, 1'b0, 1'b1);
      lookup(6, 'h050, 8'h00, 4'hE);
      expect_rsp("R4 tag parity", 1'b0, 1'b1, 2, 3);
      dwrite(6, 3, 'h050, 1'b1, 1'b1, 1'b0);
      lookup(6, 'h050, 8'h00, 4'hD);
      expect_rsp("R4 disabled parity gives hit", 1'b1, 1'b0, 0, 3);
      dwrite(7, 1, 'h0F0, 1'b0, 1'b1, 1'b0);
      lookup(7, 'h0F0, 8'h00, 4'hF);
      expect_miss("R4 invalid bad-parity way ignored");
   endtask

   task automatic t_multi;
      dwrite(8, 1, 'h0AA, 1'b1, 1'b0, 1'b0);
      dwrite(8, 4, 'h0AA, 1'b1, 1'b0, 1'b0);
      dwrite(8, 6, 'h0AA, 1'b1, 1'b0, 1'b0);
      lookup(8, 'h0AA, 8'h00, 4'hF);
      expect_rsp("R5 multi-hit second way", 1'b0, 1'b1, 3, 4);
      dwrite(8, 1, 'h0AA, 1'b1, 1'b0, 1'b0);
      dwrite(8, 4, 'h0AA, 1'b1, 1'b0, 1'b0);
      dwrite(8, 6, 'h0AA, 1'b1, 1'b0, 1'b0);
      lookup(8, 'h0AA, 8'h00, 4'hB);
      expect_rsp("R5 disabled gives highest way", 1'b1, 1'b0, 0, 6);
   endtask

   task automatic t_victim;
      for (int k = 0; k < WAYS; k++) begin
         lookup(10, 'h400 + k, 8'h00, 4'hF);
         expect_miss("R8 round robin");
      end
      lookup(10, 'h4FF, 8'h00, 4'hF);
      expect_miss("R8 wrap");
      lookup(10, 'h400, 8'h00, 4'hF);
      expect_miss("R8 overwritten line misses");
   endtask

   task automatic t_flush;
      dwrite(9, 0, 'h111, 1'b1, 1'b0, 1'b0);
      dwrite(9, 7, 'h111, 1'b1, 1'b0, 1'b0);
      dwrite(9, 3, 'h222, 1'b1, 1'b0, 1'b0);
      dwrite(9, 5, 'h555, 1'b1, 1'b0, 1'b1);
      flush(9, 'h111);
      chk("R10 flush no response", 32'(rsp_vld), 0);
      dread(9, 0); chk("R10 way 0 cleared", {dg_rd_v1, dg_rd_v0}, 0);
      dread(9, 7); chk("R10 way 7 cleared", {dg_rd_v1, dg_rd_v0}, 0);
      dread(9, 3); chk("R10 way 3 kept", {dg_rd_v1, dg_rd_v0}, 3);
      flush(9, 'h222);
      @(negedge clk);
      chk("R10 flush no response later", 32'(rsp_vld), 0);
      dread(9, 3); chk("R10 way 3 cleared", {dg_rd_v1, dg_rd_v0}, 0);
      dread(9, 5); chk("R10 pair-error way untouched", {dg_rd_v1, dg_rd_v0}, 2);
   endtask

   task automatic t_latency;
      @(negedge clk);
      lk_req = 1'b1; lk_set = 4'd11; lk_tag = 12'h9A9; chk_en = 4'hF;
      @(negedge clk);
      lk_req = 1'b0;
      chk("R1 no response after one edge", 32'(rsp_vld), 0);
      @(negedge clk);
      chk("R1 response after two edges", 32'(rsp_vld), 1);
      chk("R1 miss way", 32'(rsp_way), 32'(exp_vict));
      exp_vict = (exp_vict + 1) % WAYS;
      @(negedge clk);
      chk("R1 single-cycle strobe", 32'(rsp_vld), 0);
      chk("R1 quiet type", 32'(rsp_type), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_diag;
      t_miss_hit;
      t_ipar;
      t_vpair;
      t_tpar;
      t_multi;
      t_victim;
      t_flush;
      t_latency;
      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule